// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

This engine feeds a transmit FIFO from frames that software has placed in memory. Each frame is described by one or more descriptors of four 32-bit words: a control/status word, a word with two byte counts, a first buffer address, and a word that is either a second buffer address or a link to the next descriptor. The engine reads a descriptor and checks that it owns it. It then streams the data words of both buffers into the FIFO and writes the control/status word back with ownership handed to software. It then moves to the next descriptor, either by following the link word (chained mode) or by stepping 16 bytes through a ring that wraps to a programmed base.

The engine stops in a suspended state for one of two reasons. The first is that it meets a descriptor that software still owns. The second is that the transmitter reports an underflow while buffer data is moving, in which case the frame is aborted and the error is recorded in the descriptor. Each cause sets its own status bit and its own summary bit. While suspended, the engine keeps the address of the descriptor after the last one it closed, and a poll-demand strobe restarts it from there. Status bits are cleared by writing ones.

Top module: `txdesc_dma`

## Requirements
- R1: When the control word read has bit 31 (ownership) at 0, the engine reads no further word of that descriptor and suspends. It sets status bit 1 (buffer unavailable) and status bit 3 (normal summary), and it leaves its position on that descriptor.
- R2: Buffer 1 (count in word 1 bits [12:0], address in word 2) is streamed before buffer 2 (count in bits [28:16], address in word 3). Each buffer yields ceil(count/4) FIFO words read from ascending word addresses. A buffer whose count is zero produces no memory read.
- R3: `fifo_last` is high only on the final word of a descriptor that has bit 29 (last segment) set.
- R4: After its buffers are sent, each descriptor's control word is written back with bit 31 cleared and bits [30:16] unchanged. On a normal close, the status bits 15 and 1 are zero.
- R5: Closing a descriptor that has both bit 29 and bit 30 (interrupt on completion) set raises status bit 0. Closing any other descriptor leaves bit 0 alone.
- R6: An underflow pulse during the buffer phase stops further FIFO writes for that descriptor. The control word is written back with bits 15 and 1 set and bit 31 cleared. Status bit 2 (underflow) and bit 4 (abnormal summary) are set, status bit 0 is not raised, and the engine suspends.
- R7: In ring mode, the next descriptor is at the current address plus 16, or at `ring_base` when bit 21 (end of ring) is set. The first poll demand after reset starts at `ring_base`.
- R8: In chained mode, the next descriptor is at the address in word 3, and the buffer 2 count is ignored.
- R9: While suspended, no memory request is made. A poll demand resumes at the descriptor after the last one closed.
- R10: Status bits 0–2 are cleared by ones on `stat_clr`, with a set in the same cycle taking priority. Bit 3 is the OR of bits 0 and 1, and bit 4 follows bit 2.
- R11: An underflow pulse outside the buffer phase changes no status bit and no memory word.
- R12: A memory request stays up with a stable address until acknowledged. A buffer read is issued only while `fifo_full` is low, and each FIFO write carries read data returned in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_dmd | input | 1 | Poll-demand strobe, starts or resumes descriptor processing |
| chain_mode | input | 1 | 1: word 3 is the next-descriptor link; 0: ring stepping by 16 |
| ring_base | input | AW | Ring start address, used at first start and on end-of-ring wrap |
| tx_underflow | input | 1 | Underflow pulse from the transmitter |
| stat_clr | input | 3 | Write-one-to-clear strobes for status bits 0–2 |
| stat_o | output | 5 | Status: 0 done, 1 buffer unavailable, 2 underflow, 3 normal summary, 4 abnormal summary |
| susp_o | output | 1 | High while suspended |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a write request |
| mem_addr | output | AW | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed; read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 32 | FIFO write data |
| fifo_last | output | 1 | Marks the last word of a frame |
| fifo_full | input | 1 | FIFO cannot take another word |

## Verification
The hardest case to reach from the ports is an underflow that lands while the engine is inside a buffer transfer. The window is only a few cycles long, and it opens only after a complete descriptor fetch. The stimulus holds `fifo_full` high before issuing the poll demand, so the engine fetches the descriptor and then parks in its wait-for-space state. The bench pulses the underflow there and releases the FIFO afterwards. It then checks that no word reached the FIFO, that the written-back control word carries the error bits, and that a later poll resumes at the linked descriptor.

// File: rtl/txdesc_pkg.sv
package txdesc_pkg;
    // control word bit positions (word 0)
    localparam int OWN_BIT  = 31;
    localparam int IOC_BIT  = 30;
    localparam int LS_BIT   = 29;
    localparam int EOR_BIT  = 21;
    localparam int CTL_LO   = 16;
    localparam int CTL_W    = OWN_BIT - CTL_LO;     // bits [30:16]
    localparam int IOC_IDX  = IOC_BIT - CTL_LO;
    localparam int LS_IDX   = LS_BIT - CTL_LO;
    localparam int EOR_IDX  = EOR_BIT - CTL_LO;

    // byte counts (word 1)
    localparam int CNT_W    = 13;
    localparam int CNT2_LO  = 16;

    // status register layout
    localparam int ST_SRC   = 3;                    // w1c source bits
    localparam int ST_W     = ST_SRC + 2;
    localparam int ST_DONE  = 0;
    localparam int ST_BUNAV = 1;
    localparam int ST_UNFL  = 2;
    localparam int ST_NSUM  = 3;
    localparam int ST_ASUM  = 4;

    typedef enum logic [3:0] {
        S_IDLE, S_F0, S_F1, S_F2, S_F3, S_DWAIT, S_DREQ, S_WB, S_SUSP
    } txd_state_e;
endpackage

// File: rtl/txdesc_stat.sv
module txdesc_stat
    import txdesc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ST_SRC-1:0] set_i,
    input  logic [ST_SRC-1:0] clr_i,
    output logic [ST_W-1:0]   stat_o
);
    logic [ST_SRC-1:0] src_d, src_q;

    for (genvar i = 0; i < ST_SRC; i++) begin : g_bit
        always_comb src_d[i] = set_i[i] | (src_q[i] & ~clr_i[i]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_d;
    end

    assign stat_o = {src_q[ST_UNFL], src_q[ST_DONE] | src_q[ST_BUNAV], src_q};
endmodule

// File: rtl/txdesc_nextptr.sv
module txdesc_nextptr #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur_i,
    input  logic [AW-1:0] link_i,
    input  logic [AW-1:0] base_i,
    input  logic          chain_i,
    input  logic          eor_i,
    output logic [AW-1:0] nxt_o
);
    localparam int DESC_BYTES = 16;

    always_comb begin
        if (chain_i)    nxt_o = link_i;
        else if (eor_i) nxt_o = base_i;
        else            nxt_o = cur_i + AW'(DESC_BYTES);
    end
endmodule

// File: rtl/txdesc_ctrl.sv
module txdesc_ctrl
    import txdesc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              poll_i,
    input  logic              chain_i,
    input  logic [AW-1:0]     base_i,
    input  logic              unf_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [31:0]       mem_rdata_i,
    output logic              fifo_wr_o,
    output logic [31:0]       fifo_data_o,
    output logic              fifo_last_o,
    input  logic              fifo_full_i,
    input  logic [AW-1:0]     nxt_i,
    output logic [AW-1:0]     cur_o,
    output logic [AW-1:0]     link_o,
    output logic              eor_o,
    output logic [ST_SRC-1:0] set_o,
    output logic              susp_o
);
    localparam int WORD_BYTES = 4;

    typedef struct packed {
        txd_state_e       st;
        logic [AW-1:0]    ptr;
        logic [CTL_W-1:0] ctl;
        logic [CNT_W-1:0] cnt1;
        logic [CNT_W-1:0] cnt2;
        logic [AW-1:0]    a1;
        logic [AW-1:0]    a2;
        logic [AW-1:0]    baddr;
        logic [CNT_W-1:0] rem;
        logic             bsel;
        logic             abrt;
    } ctrl_t;

    ctrl_t r_d, r_q;
    logic  abrt_now;
    logic  last_word;
    logic  use_b2;

    always_comb begin
        r_d         = r_q;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = r_q.ptr;
        mem_wdata_o = {1'b0, r_q.ctl, r_q.abrt, 13'b0, r_q.abrt, 1'b0};
        fifo_wr_o   = 1'b0;
        fifo_data_o = mem_rdata_i;
        fifo_last_o = 1'b0;
        set_o       = '0;
        abrt_now    = r_q.abrt | unf_i;
        use_b2      = !chain_i && (r_q.cnt2 != '0);
        last_word   = r_q.rem <= CNT_W'(WORD_BYTES);

        unique case (r_q.st)
            S_IDLE: if (poll_i) begin
                r_d.ptr = base_i;
                r_d.st  = S_F0;
            end
            S_SUSP: if (poll_i) r_d.st = S_F0;
            S_F0: begin
                mem_req_o = 1'b1;
                if (mem_ack_i) begin
                    r_d.ctl  = mem_rdata_i[OWN_BIT-1:CTL_LO];
                    r_d.abrt = 1'b0;
                    if (!mem_rdata_i[OWN_BIT]) begin
                        set_o[ST_BUNAV] = 1'b1;
                        r_d.st          = S_SUSP;
                    end else begin
                        r_d.st = S_F1;
                    end
                end
            end
            S_F1: begin
                mem_req_o  = 1'b1;
                mem_addr_o = r_q.ptr + AW'(4);
                if (mem_ack_i) begin
                    r_d.cnt1 = mem_rdata_i[CNT_W-1:0];
                    r_d.cnt2 = mem_rdata_i[CNT2_LO+CNT_W-1:CNT2_LO];
                    r_d.st   = S_F2;
                end
            end
            S_F2: begin
                mem_req_o  = 1'b1;
                mem_addr_o = r_q.ptr + AW'(8);
                if (mem_ack_i) begin
                    r_d.a1 = mem_rdata_i[AW-1:0];
                    r_d.st = S_F3;
                end
            end
            S_F3: begin
                mem_req_o  = 1'b1;
                mem_addr_o = r_q.ptr + AW'(12);
                if (mem_ack_i) begin
                    r_d.a2 = mem_rdata_i[AW-1:0];
                    if (r_q.cnt1 != '0) begin
                        r_d.bsel  = 1'b0;
                        r_d.baddr = r_q.a1;
                        r_d.rem   = r_q.cnt1;
                        r_d.st    = S_DWAIT;
                    end else if (use_b2) begin
                        r_d.bsel  = 1'b1;
                        r_d.baddr = mem_rdata_i[AW-1:0];
                        r_d.rem   = r_q.cnt2;
                        r_d.st    = S_DWAIT;
                    end else begin
                        r_d.st = S_WB;
                    end
                end
            end
            S_DWAIT: begin
                r_d.abrt = abrt_now;
                if (abrt_now)          r_d.st = S_WB;
                else if (!fifo_full_i) r_d.st = S_DREQ;
            end
            S_DREQ: begin
                mem_req_o  = 1'b1;
                mem_addr_o = r_q.baddr;
                r_d.abrt   = abrt_now;
                if (mem_ack_i) begin
                    if (abrt_now) begin
                        r_d.st = S_WB;
                    end else begin
                        fifo_wr_o   = 1'b1;
                        fifo_last_o = r_q.ctl[LS_IDX] && last_word && (r_q.bsel || !use_b2);
                        r_d.baddr   = r_q.baddr + AW'(WORD_BYTES);
                        if (!last_word) begin
                            r_d.rem = r_q.rem - CNT_W'(WORD_BYTES);
                            r_d.st  = S_DWAIT;
                        end else if (!r_q.bsel && use_b2) begin
                            r_d.bsel  = 1'b1;
                            r_d.baddr = r_q.a2;
                            r_d.rem   = r_q.cnt2;
                            r_d.st    = S_DWAIT;
                        end else begin
                            r_d.st = S_WB;
                        end
                    end
                end
            end
            S_WB: begin
                mem_req_o = 1'b1;
                mem_we_o  = 1'b1;
                if (mem_ack_i) begin
                    r_d.ptr = nxt_i;
                    if (r_q.abrt) begin
                        set_o[ST_UNFL] = 1'b1;
                        r_d.st         = S_SUSP;
                    end else begin
                        set_o[ST_DONE] = r_q.ctl[LS_IDX] & r_q.ctl[IOC_IDX];
                        r_d.st         = S_F0;
                    end
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign cur_o  = r_q.ptr;
    assign link_o = r_q.a2;
    assign eor_o  = r_q.ctl[EOR_IDX];
    assign susp_o = (r_q.st == S_SUSP);
endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma
    import txdesc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            poll_dmd,
    input  logic            chain_mode,
    input  logic [AW-1:0]   ring_base,
    input  logic            tx_underflow,
    input  logic [2:0]      stat_clr,
    output logic [4:0]      stat_o,
    output logic            susp_o,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [31:0]     mem_wdata,
    input  logic            mem_ack,
    input  logic [31:0]     mem_rdata,
    output logic            fifo_wr,
    output logic [31:0]     fifo_wdata,
    output logic            fifo_last,
    input  logic            fifo_full
);
    logic [AW-1:0]     cur, link, nxt;
    logic              eor;
    logic [ST_SRC-1:0] set;

    txdesc_ctrl #(.AW(AW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .poll_i      (poll_dmd),
        .chain_i     (chain_mode),
        .base_i      (ring_base),
        .unf_i       (tx_underflow),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_ack_i   (mem_ack),
        .mem_rdata_i (mem_rdata),
        .fifo_wr_o   (fifo_wr),
        .fifo_data_o (fifo_wdata),
        .fifo_last_o (fifo_last),
        .fifo_full_i (fifo_full),
        .nxt_i       (nxt),
        .cur_o       (cur),
        .link_o      (link),
        .eor_o       (eor),
        .set_o       (set),
        .susp_o      (susp_o)
    );

    txdesc_nextptr #(.AW(AW)) u_next (
        .cur_i   (cur),
        .link_i  (link),
        .base_i  (ring_base),
        .chain_i (chain_mode),
        .eor_i   (eor),
        .nxt_o   (nxt)
    );

    txdesc_stat u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set),
        .clr_i  (stat_clr),
        .stat_o (stat_o)
    );
endmodule

// File: rtl/txdesc_dma_chk.sv
module txdesc_dma_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          poll_dmd,
    input logic [4:0]    stat_o,
    input logic          susp_o,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_ack,
    input logic          fifo_wr
);
    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    // R12
    fifo_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> mem_ack && !mem_we);

    // R4
    wb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_wdata[31]);

    // R1
    bu_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_o[1]) |-> susp_o);

    // R6
    unf_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_o[2]) |-> susp_o);

    // R9
    susp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        susp_o && !poll_dmd |=> !mem_req);
endmodule

bind txdesc_dma txdesc_dma_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .poll_dmd  (poll_dmd),
    .stat_o    (stat_o),
    .susp_o    (susp_o),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .fifo_wr   (fifo_wr)
);

// File: tb/txdesc_dma_test.sv
module txdesc_dma_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        poll_dmd = 1'b0;
    logic        chain_mode = 1'b0;
    logic [31:0] ring_base = 32'h100;
    logic        tx_underflow = 1'b0;
    logic [2:0]  stat_clr = 3'b0;
    logic [4:0]  stat_o;
    logic        susp_o;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic        fifo_wr, fifo_last;
    logic [31:0] fifo_wdata;
    logic        fifo_full = 1'b0;

    logic [31:0] mem [0:255];
    logic        ld_we = 1'b0;
    logic [7:0]  ld_idx = '0;
    logic [31:0] ld_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    logic [32:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    txdesc_dma #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .poll_dmd(poll_dmd), .chain_mode(chain_mode),
        .ring_base(ring_base), .tx_underflow(tx_underflow), .stat_clr(stat_clr),
        .stat_o(stat_o), .susp_o(susp_o), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .fifo_last(fifo_last), .fifo_full(fifo_full)
    );

    // memory model: one-cycle acknowledge, plus a loader port for the bench
    always @(posedge clk) begin
        if (ld_we) mem[ld_idx] <= ld_data;
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[9:2]];
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // monitor: pops expected FIFO words (R2, R3)
    always @(negedge clk) begin
        if (rst_n && fifo_wr) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2 unexpected fifo word: actual=%h expected=none", fifo_wdata);
            end else begin
                logic [32:0] e;
                e = exp_q.pop_front();
                if ({fifo_last, fifo_wdata} !== e) begin
                    n_fail++;
                    $display("FAIL R2/R3 fifo word: actual=%0b_%h expected=%0b_%h",
                             fifo_last, fifo_wdata, e[32], e[31:0]);
                end
            end
        end
    end

    function automatic logic [31:0] pat(input logic [31:0] a);
        return 32'hD5A0_0000 ^ (a * 32'h0001_0003);
    endfunction

    function automatic logic [31:0] w0(input logic own, ioc, ls, eor);
        return {own, ioc, ls, 7'b0, eor, 21'b0};
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_mem(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        ld_we = 1'b1; ld_idx = a[9:2]; ld_data = d;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] a, ctl, input int c1, c2,
                            input logic [31:0] b1, w3);
        wr_mem(a + 4, {3'b0, 13'(c2), 3'b0, 13'(c1)});
        wr_mem(a + 8, b1);
        wr_mem(a + 12, w3);
        wr_mem(a, ctl);
    endtask

    // driver side of the scoreboard: fill a buffer and queue its words
    task automatic push_buf(input logic [31:0] b, input int cnt, input logic last);
        int n;
        n = (cnt + 3) / 4;
        for (int i = 0; i < n; i++) begin
            wr_mem(b + 32'(4*i), pat(b + 32'(4*i)));
            exp_q.push_back({last && (i == n-1), pat(b + 32'(4*i))});
        end
    endtask

    task automatic poll();
        @(negedge clk); poll_dmd = 1'b1;
        @(negedge clk); poll_dmd = 1'b0;
    endtask

    task automatic wait_susp();
        for (int i = 0; i < 2000 && !susp_o; i++) @(negedge clk);
    endtask

    task automatic clear(input logic [2:0] m);
        @(negedge clk); stat_clr = m;
        @(negedge clk); stat_clr = 3'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int reqs;
        for (int i = 0; i < 256; i++) wr_mem(32'(4*i), 32'h0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(stat_o == 5'b0 && !susp_o && !mem_req, "R10 reset state",
            {26'b0, susp_o, stat_o}, 32'h0);

        // ---- ring mode: three descriptors, two frames ----
        push_buf(32'h200, 8, 1'b0);
        push_buf(32'h240, 5, 1'b1);
        put_desc(32'h100, w0(1,1,1,0), 8, 5, 32'h200, 32'h240);
        push_buf(32'h260, 4, 1'b0);
        put_desc(32'h110, w0(1,0,0,0), 4, 0, 32'h260, 32'h0);
        push_buf(32'h280, 12, 1'b1);
        put_desc(32'h120, w0(1,0,1,1), 0, 12, 32'h0, 32'h280);
        poll();
        wait_susp();
        chk(exp_q.size() == 0, "R2 ring frames all streamed", exp_q.size(), 0);
        chk(mem[32'h100 >> 2] == w0(0,1,1,0), "R4 desc0 released", mem[64], w0(0,1,1,0));
        chk(mem[32'h110 >> 2] == w0(0,0,0,0), "R4 desc1 released", mem[68], w0(0,0,0,0));
        chk(mem[32'h120 >> 2] == w0(0,0,1,1), "R4 desc2 released", mem[72], w0(0,0,1,1));
        // R7 wrap to base found the released desc0 -> R1 buffer unavailable, R5 done
        chk(stat_o == 5'b01011, "R1 R5 R7 status after ring", stat_o, 5'b01011);
        chk(susp_o, "R1 suspended", susp_o, 1);

        clear(3'b011);
        chk(stat_o == 5'b0, "R10 w1c clear", stat_o, 0);

        // R9 / R11: quiet while suspended, underflow ignored
        reqs = 0;
        for (int i = 0; i < 20; i++) begin
            if (i == 5) tx_underflow = 1'b1;
            if (i == 6) tx_underflow = 1'b0;
            @(negedge clk);
            if (mem_req) reqs++;
        end
        chk(reqs == 0, "R9 no requests while suspended", reqs, 0);
        chk(stat_o == 5'b0 && susp_o, "R11 underflow outside buffer ignored", stat_o, 0);
        chk(mem[32'h100 >> 2] == w0(0,1,1,0), "R11 memory untouched", mem[64], w0(0,1,1,0));

        // ---- chained mode, underflow abort while FIFO is full ----
        chain_mode = 1'b1;
        fifo_full = 1'b1;
        wr_mem(32'h2C0, pat(32'h2C0));
        wr_mem(32'h2C4, pat(32'h2C4));
        put_desc(32'h100, w0(1,1,1,0), 8, 0, 32'h2C0, 32'h180);
        poll();
        repeat (40) @(negedge clk);
        chk(!susp_o, "R12 parked waiting for FIFO space", susp_o, 0);
        tx_underflow = 1'b1;
        @(negedge clk);
        tx_underflow = 1'b0;
        fifo_full = 1'b0;
        wait_susp();
        chk(mem[32'h100 >> 2] == (w0(0,1,1,0) | 32'h8002), "R6 error written back",
            mem[64], w0(0,1,1,0) | 32'h8002);
        chk(stat_o == 5'b10100, "R6 underflow status, no done", stat_o, 5'b10100);
        chk(exp_q.size() == 0, "R6 no words from aborted desc", exp_q.size(), 0);

        clear(3'b100);
        chk(stat_o == 5'b0, "R10 clear underflow", stat_o, 0);

        // R8 / R9: resume at link, buffer 2 count ignored in chain mode
        push_buf(32'h2E0, 8, 1'b1);
        put_desc(32'h180, w0(1,1,1,0), 8, 4, 32'h2E0, 32'h1A0);
        poll();
        wait_susp();
        chk(exp_q.size() == 0, "R8 R9 resumed at linked desc", exp_q.size(), 0);
        chk(mem[32'h180 >> 2] == w0(0,1,1,0), "R4 chained desc released", mem[96], w0(0,1,1,0));
        chk(stat_o == 5'b01011, "R5 R1 status after chain", stat_o, 5'b01011);

        // R9: position kept on unavailable descriptor; R5: no IOC -> no done
        clear(3'b011);
        push_buf(32'h300, 3, 1'b1);
        put_desc(32'h1A0, w0(1,0,1,0), 3, 0, 32'h300, 32'h1C0);
        poll();
        wait_susp();
        chk(exp_q.size() == 0, "R9 resumed at unavailable desc", exp_q.size(), 0);
        chk(stat_o == 5'b01010, "R5 no done without IOC", stat_o, 5'b01010);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule